// File: doc/BRIEF.md
# SCL Clock Synchronizer

This block produces the serial clock of an I2C-style master. A reloadable down-counter advances only on count-source ticks. Each time it expires it flips an internal clock and reloads. The block shares an open-drain SCL line with other devices. It pulls the line low while its internal clock is low and lets it float while the clock is high. The level it reads back from the pad goes through a two-stage synchronizer before the block uses it.

With synchronization enabled, the block follows other devices on the line. A falling edge on the line during the block's high phase cuts that phase short and starts a fresh low phase. A device that keeps the line low after the block has released it makes the counter wait. The transfer clock given to the bit logic is the AND of the internal clock and the synchronized line level. Three overrides act on the line drive: a hold after the ninth clock, a release when a stop condition is detected, and a force-low that works at any time. Bit sequencing, START/STOP generation and arbitration belong to other blocks.

Top module: `scl_clock_sync`

## Requirements
- R1: While reset is applied and right after it, `scl_drive_low_o` is 0 (line released) and `xfer_clk_o` is 1.
- R2: The counter moves only on cycles with `tick_i` high. Each phase of the internal clock lasts `reload_i`+1 ticks (with sync disabled, a ticked cycle every N cycles gives (`reload_i`+1)*N cycles). Without ticks the drive does not change.
- R3: With `sync_en_i` high, a falling line level seen while the internal clock is high drives the line low 3 cycles after the pad falls (2 synchronizer stages plus 1 register). A low phase of `reload_i`+1 ticks follows. With `sync_en_i` low the same pulse has no effect.
- R4: With `sync_en_i` high and the internal clock high, the counter stops while the synchronized line is low. After the pad goes high, the line is pulled low again `reload_i`+3 cycles later (tick every cycle).
- R5: `xfer_clk_o` is the AND of the internal clock and the synchronized line. With sync enabled and a tick every cycle, each high pulse lasts `reload_i`+1 cycles.
- R6: Falling edges of the internal clock are counted modulo 9. At the ninth, if `hold_ninth_en_i` is high, the line stays pulled low until that control is cleared. The line is released `reload_i`+2 cycles after clearing (tick every cycle).
- R7: A `stop_det_i` pulse while `stop_release_en_i` is high releases the line from the next cycle. The internal clock is parked high and the counter is held until `stop_release_en_i` is cleared. The line is pulled low again `reload_i`+2 cycles later (tick every cycle).
- R8: `force_low_i` high sets `scl_drive_low_o` to 1 in the same cycle, in every state, including the released state. When it is cleared, normal toggling resumes.
- R9: When `stop_det_i` arrives in the same cycle as the ninth falling edge, the stop wins. No hold is recorded, and with release enabled the line is released.
- R10: `stop_det_i` restarts the falling-edge count, so the ninth edge after a stop is the one that holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Count-source enable, one cycle per counter step |
| reload_i | input | CNT_W | Half-period length minus one, in ticks |
| sync_en_i | input | 1 | Enable synchronization to the line |
| force_low_i | input | 1 | Pull the line low unconditionally |
| hold_ninth_en_i | input | 1 | Hold the line low after the ninth falling edge |
| stop_release_en_i | input | 1 | Release the line when a stop is detected |
| scl_pin_i | input | 1 | Level read back from the SCL pad |
| stop_det_i | input | 1 | One-cycle stop-detected pulse |
| scl_drive_low_o | output | 1 | 1 = pull the line low, 0 = release (high impedance) |
| xfer_clk_o | output | 1 | Effective transfer clock |

## Verification
The ninth-edge hold and the stop release can land on the same clock edge, and R9 covers that case. The bench counts eight falling edges from a known stop with synchronization off, so the phase length is exact. It then pulses `stop_det_i` in the cycle just before the ninth edge. It checks that the line is released at once. When the release control is cleared, the line must next be pulled low after the normal `reload_i`+2 cycles, not straight away as a leftover hold would cause.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;

  // Action chosen by the half-period timer in a given cycle
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_PARK,
    ACT_FREEZE,
    ACT_RESYNC,
    ACT_STALL,
    ACT_EXPIRE,
    ACT_COUNT
  } tmr_act_e;

  // Line ownership state kept by the control logic
  typedef struct packed {
    logic held;
    logic released;
  } line_state_t;

endpackage

// File: rtl/scl_pin_sync.sv
module scl_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              last_q;

  generate
    if (STAGES > 1) begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], pin_i};
    end else begin : g_single
      assign chain_d = pin_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/scl_half_timer.sv
module scl_half_timer
  import scl_sync_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             sync_en_i,
  input  logic             pin_lvl_i,
  input  logic             pin_fall_i,
  input  logic             freeze_i,
  input  logic             park_i,
  output logic             clk_int_o,
  output logic             fall_evt_o
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             clk_q, clk_d;
  logic             upd_en;
  tmr_act_e         act;

  // Priority: park > freeze > resync > (tick: stall / expire / count)
  always_comb begin
    act = ACT_IDLE;
    if (park_i) begin
      act = ACT_PARK;
    end else if (freeze_i) begin
      act = ACT_FREEZE;
    end else if (sync_en_i && pin_fall_i && clk_q) begin
      act = ACT_RESYNC;
    end else if (tick_i) begin
      if (sync_en_i && clk_q && !pin_lvl_i) begin
        act = ACT_STALL;
      end else if (cnt_q == CNT_ZERO) begin
        act = ACT_EXPIRE;
      end else begin
        act = ACT_COUNT;
      end
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    clk_d = clk_q;
    case (act)
      ACT_PARK: begin
        cnt_d = reload_i;
        clk_d = 1'b1;
      end
      ACT_RESYNC: begin
        cnt_d = reload_i;
        clk_d = 1'b0;
      end
      ACT_EXPIRE: begin
        cnt_d = reload_i;
        clk_d = ~clk_q;
      end
      ACT_COUNT: begin
        cnt_d = cnt_q - CNT_ONE;
      end
      default: begin
        cnt_d = cnt_q;
        clk_d = clk_q;
      end
    endcase
  end

  assign upd_en = (act == ACT_PARK) || (act == ACT_RESYNC) ||
                  (act == ACT_EXPIRE) || (act == ACT_COUNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_ZERO;
      clk_q <= 1'b1;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      clk_q <= clk_d;
    end
  end

  assign clk_int_o  = clk_q;
  assign fall_evt_o = clk_q & ~clk_d;

  AST_RESYNC_PULLS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_en_i && pin_fall_i && clk_q && !park_i && !freeze_i) |=> !clk_q); // R3

  AST_STALL_KEEPS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_en_i && clk_q && !pin_lvl_i && !pin_fall_i && !park_i && !freeze_i)
      |=> (clk_q && $stable(cnt_q))); // R4

  AST_PARK_GOES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    park_i |=> clk_q); // R7

  AST_EDGE_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_q != $past(clk_q)) |-> ($past(tick_i) || $past(pin_fall_i) || $past(park_i))); // R2

endmodule

// File: rtl/scl_line_ctrl.sv
module scl_line_ctrl
  import scl_sync_pkg::*;
#(
  parameter int FRAME_BITS = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_evt_i,
  input  logic stop_det_i,
  input  logic hold_ninth_en_i,
  input  logic stop_release_en_i,
  input  logic force_low_i,
  input  logic clk_int_i,
  output logic held_o,
  output logic released_o,
  output logic drive_low_o
);

  localparam int FCW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [FCW-1:0] LAST_SLOT = FCW'(FRAME_BITS - 1);
  localparam logic [FCW-1:0] SLOT_ONE  = FCW'(1);

  logic [FCW-1:0] slot_q, slot_d;
  line_state_t    st_q, st_d;

  always_comb begin
    slot_d = slot_q;
    st_d   = st_q;
    if (stop_det_i) begin
      // a stop outranks a coinciding ninth edge
      slot_d      = '0;
      st_d.held   = 1'b0;
      st_d.released = st_q.released | stop_release_en_i;
    end else begin
      if (st_q.released && !stop_release_en_i) begin
        st_d.released = 1'b0;
      end
      if (st_q.held && !hold_ninth_en_i) begin
        st_d.held = 1'b0;
      end
      if (fall_evt_i) begin
        if (slot_q == LAST_SLOT) begin
          slot_d = '0;
          if (hold_ninth_en_i) begin
            st_d.held = 1'b1;
          end
        end else begin
          slot_d = slot_q + SLOT_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      st_q   <= '0;
    end else begin
      slot_q <= slot_d;
      st_q   <= st_d;
    end
  end

  assign held_o      = st_q.held;
  assign released_o  = st_q.released;
  assign drive_low_o = force_low_i | (~st_q.released & (st_q.held | ~clk_int_i));

  AST_HOLD_AT_NINTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q.held) |-> ($past(fall_evt_i) && ($past(slot_q) == LAST_SLOT))); // R6

  AST_SLOT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= LAST_SLOT); // R6

  AST_STOP_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_i |=> ((slot_q == '0) && !st_q.held)); // R10

  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det_i && stop_release_en_i) |=> st_q.released); // R7

endmodule

// File: rtl/scl_clock_sync.sv
module scl_clock_sync #(
  parameter int CNT_W       = 8,
  parameter int FRAME_BITS  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             sync_en_i,
  input  logic             force_low_i,
  input  logic             hold_ninth_en_i,
  input  logic             stop_release_en_i,
  input  logic             scl_pin_i,
  input  logic             stop_det_i,
  output logic             scl_drive_low_o,
  output logic             xfer_clk_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_n_int;
  logic       pin_lvl;
  logic       pin_fall;
  logic       clk_int;
  logic       fall_evt;
  logic       held;
  logic       released;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe_q[1];

  scl_pin_sync #(
    .STAGES (SYNC_STAGES)
  ) u_pin (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .pin_i   (scl_pin_i),
    .level_o (pin_lvl),
    .fall_o  (pin_fall)
  );

  scl_half_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .tick_i     (tick_i),
    .reload_i   (reload_i),
    .sync_en_i  (sync_en_i),
    .pin_lvl_i  (pin_lvl),
    .pin_fall_i (pin_fall),
    .freeze_i   (held),
    .park_i     (released),
    .clk_int_o  (clk_int),
    .fall_evt_o (fall_evt)
  );

  scl_line_ctrl #(
    .FRAME_BITS (FRAME_BITS)
  ) u_ctrl (
    .clk_i             (clk_i),
    .rst_ni            (rst_n_int),
    .fall_evt_i        (fall_evt),
    .stop_det_i        (stop_det_i),
    .hold_ninth_en_i   (hold_ninth_en_i),
    .stop_release_en_i (stop_release_en_i),
    .force_low_i       (force_low_i),
    .clk_int_i         (clk_int),
    .held_o            (held),
    .released_o        (released),
    .drive_low_o       (scl_drive_low_o)
  );

  assign xfer_clk_o = clk_int & pin_lvl;

  AST_HOLD_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    held |-> !clk_int); // R6

  AST_HELD_BLOCKS_EDGES: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (held && $past(held) && !released) |-> !fall_evt); // R6

endmodule

// File: tb/sim_scl_clock_sync.sv
module sim_scl_clock_sync;

  localparam int CLK_PERIOD = 10;
  localparam int CW         = 8;
  localparam int WD_LIMIT   = 100000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tick;
  logic [CW-1:0] reload;
  logic          sync_en, force_low, hold9, stop_rel, stop_det, ext_low;
  wire           scl_pin;
  logic          drive_low, xfer_clk;

  int tick_div = 1;
  int tick_ph  = 0;
  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_pin = ~(drive_low | ext_low);

  scl_clock_sync #(.CNT_W(CW)) u0 (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .tick_i            (tick),
    .reload_i          (reload),
    .sync_en_i         (sync_en),
    .force_low_i       (force_low),
    .hold_ninth_en_i   (hold9),
    .stop_release_en_i (stop_rel),
    .scl_pin_i         (scl_pin),
    .stop_det_i        (stop_det),
    .scl_drive_low_o   (drive_low),
    .xfer_clk_o        (xfer_clk)
  );

  initial begin
    tick = 1'b0;
    forever begin
      @(negedge clk);
      tick_ph++;
      tick = ((tick_ph % tick_div) == 0);
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WD_LIMIT);
    summary();
    $finish;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_for(input logic v, output int n);
    n = 0;
    while (drive_low !== v && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_len(input logic v, output int n);
    n = 0;
    while (drive_low === v && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input int r, input logic s, input int div);
    @(negedge clk);
    rst_n = 1'b0;
    force_low = 1'b0; hold9 = 1'b0; stop_rel = 1'b0; stop_det = 1'b0; ext_low = 1'b0;
    reload = CW'(r); sync_en = s; tick_div = div;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    int bad;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "drive in reset", int'(drive_low), 0);
    check("R1", "xfer clock in reset", int'(xfer_clk), 1);
    tick_div = 1000000;
    rst_n = 1'b1;
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (drive_low !== 1'b0) bad++;
    end
    check("R2", "drive toggles without ticks", bad, 0);
  endtask

  task automatic t_period();
    int n;
    do_reset(3, 1'b0, 1);
    wait_for(1'b1, n);
    run_len(1'b1, n);
    check("R2", "low phase, tick every cycle", n, 4);
    run_len(1'b0, n);
    check("R2", "high phase, tick every cycle", n, 4);
    do_reset(3, 1'b0, 2);
    wait_for(1'b1, n);
    run_len(1'b1, n);
    check("R2", "low phase, tick every 2nd cycle", n, 8);
    run_len(1'b0, n);
    check("R2", "high phase, tick every 2nd cycle", n, 8);
  endtask

  task automatic t_stretch();
    int n, bad;
    do_reset(3, 1'b1, 1);
    wait_for(1'b0, n);
    wait_for(1'b1, n);
    ext_low = 1'b1;
    wait_for(1'b0, n);
    bad = 0;
    repeat (8) begin
      @(negedge clk);
      if (drive_low !== 1'b0 || xfer_clk !== 1'b0) bad++;
    end
    check("R4", "stall while line held by other device", bad, 0);
    ext_low = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (drive_low !== 1'b1 && n < 100);
    check("R4", "cycles from line release to next pull", n, 6);
    n = 0;
    while (xfer_clk !== 1'b0 && n < 100) begin @(negedge clk); n++; end
    while (xfer_clk !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    n = 0;
    while (xfer_clk === 1'b1 && n < 100) begin n++; @(negedge clk); end
    check("R5", "transfer clock high pulse", n, 4);
  endtask

  task automatic t_resync();
    int n, bad;
    do_reset(20, 1'b1, 1);
    wait_for(1'b1, n);
    wait_for(1'b0, n);
    repeat (6) @(negedge clk);
    ext_low = 1'b1;
    n = 0;
    @(negedge clk);
    n++;
    ext_low = 1'b0;
    while (drive_low !== 1'b1 && n < 50) begin @(negedge clk); n++; end
    check("R3", "pull delay after external fall", n, 3);
    run_len(1'b1, n);
    check("R3", "low phase after resync", n, 21);
    do_reset(20, 1'b0, 1);
    wait_for(1'b1, n);
    wait_for(1'b0, n);
    repeat (6) @(negedge clk);
    ext_low = 1'b1;
    @(negedge clk);
    ext_low = 1'b0;
    bad = 0;
    repeat (10) begin
      @(negedge clk);
      if (drive_low !== 1'b0) bad++;
    end
    check("R3", "external fall ignored with sync off", bad, 0);
  endtask

  task automatic t_hold();
    int n, bad;
    do_reset(3, 1'b0, 1);
    wait_for(1'b1, n);
    wait_for(1'b0, n);
    stop_det = 1'b1;
    hold9 = 1'b1;
    @(negedge clk);
    stop_det = 1'b0;
    for (int i = 1; i <= 9; i++) begin
      wait_for(1'b1, n);
      if (i == 8) begin
        run_len(1'b1, n);
        check("R10", "eighth low phase after stop not held", n, 4);
      end else if (i < 9) begin
        wait_for(1'b0, n);
      end
    end
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (drive_low !== 1'b1) bad++;
    end
    check("R6", "line held low after ninth edge", bad, 0);
    hold9 = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (drive_low !== 1'b0 && n < 100);
    check("R6", "cycles from hold clear to release", n, 5);
  endtask

  task automatic t_release();
    int n, bad;
    do_reset(3, 1'b1, 1);
    stop_rel = 1'b1;
    wait_for(1'b0, n);
    wait_for(1'b1, n);
    stop_det = 1'b1;
    @(negedge clk);
    stop_det = 1'b0;
    check("R7", "line released after stop", int'(drive_low), 0);
    bad = 0;
    repeat (30) begin
      @(negedge clk);
      if (drive_low !== 1'b0) bad++;
    end
    check("R7", "line stays released", bad, 0);
    check("R7", "transfer clock parked high", int'(xfer_clk), 1);
    force_low = 1'b1;
    #1;
    check("R8", "force low wins over released state", int'(drive_low), 1);
    @(negedge clk);
    force_low = 1'b0;
    repeat (10) @(negedge clk);
    stop_rel = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (drive_low !== 1'b1 && n < 100);
    check("R7", "cycles from release clear to next pull", n, 5);
  endtask

  task automatic t_force();
    int n, bad, n2;
    do_reset(3, 1'b1, 1);
    wait_for(1'b1, n);
    wait_for(1'b0, n);
    force_low = 1'b1;
    #1;
    check("R8", "force low same cycle", int'(drive_low), 1);
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (drive_low !== 1'b1) bad++;
    end
    check("R8", "force low kept", bad, 0);
    force_low = 1'b0;
    wait_for(1'b0, n);
    wait_for(1'b1, n2);
    check("R8", "toggling resumes after force", int'(n < 500 && n2 < 500), 1);
  endtask

  task automatic t_coincide();
    int n, bad;
    do_reset(3, 1'b0, 1);
    wait_for(1'b1, n);
    wait_for(1'b0, n);
    stop_det = 1'b1;
    hold9 = 1'b1;
    @(negedge clk);
    stop_det = 1'b0;
    stop_rel = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      wait_for(1'b1, n);
      if (i < 8) wait_for(1'b0, n);
    end
    repeat (7) @(negedge clk);
    check("R9", "high phase before ninth edge", int'(drive_low), 0);
    stop_det = 1'b1;
    @(negedge clk);
    stop_det = 1'b0;
    #1;
    check("R9", "stop on ninth edge releases line", int'(drive_low), 0);
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (drive_low !== 1'b0) bad++;
    end
    check("R9", "line stays released", bad, 0);
    stop_rel = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (drive_low !== 1'b1 && n < 100);
    check("R9", "no leftover hold after coinciding stop", n, 5);
  endtask

  initial begin
    rst_n = 1'b0;
    reload = '0; sync_en = 1'b0; force_low = 1'b0; hold9 = 1'b0;
    stop_rel = 1'b0; stop_det = 1'b0; ext_low = 1'b0;
    t_reset();
    t_period();
    t_stretch();
    t_resync();
    t_hold();
    t_release();
    t_force();
    t_coincide();
    summary();
    $finish;
  end

endmodule